// File: doc/BRIEF.md
# DRAM Subcommand Dispatch and Issue

This block holds DRAM command combinations (an optional precharge, an optional row activate, and a column access that may carry auto-precharge). Reads go into one subqueue and writes into another. Each stored entry runs its own small state machine through the subcommands its combination needs. The pending subcommand of every live entry is merged into one ready vector, with one bit per subcommand kind per DIMM.

A round-robin issue selector picks one set bit per cycle, so subcommands of different entries can leave out of arrival order. The chosen kind/DIMM pair goes back to both subqueues. Only the oldest live entry pending that kind for that DIMM executes, across both subqueues. The issued subcommand leaves on a registered output carrying the entry's DIMM, direction and transaction tag. The entry then steps to its next subcommand, or it frees itself after the column access.

An upstream timing stage can hold off issue with `issue_enable`. Per-direction occupancy counts let the producer avoid overrunning a full subqueue. `NUM_DIMM` must be a power of two.

Entry states: `ST_IDLE`, `ST_WAIT_PRE`, `ST_WAIT_RAS`, `ST_WAIT_CAS`, `ST_WAIT_CASAP`. Transitions:
- alloc: `ST_IDLE` goes to the first needed state.
- pre_done: `ST_WAIT_PRE` goes to `ST_WAIT_RAS`, or to the final state when no activate is needed.
- ras_done: `ST_WAIT_RAS` goes to the final state.
- retire: `ST_WAIT_CAS` or `ST_WAIT_CASAP` goes to `ST_IDLE`.

Top module: `sdq_dispatch_issue`

## Requirements
- R1: A combination offered with `cmb_valid`=1 goes to the write subqueue when `cmb_write`=1 and to the read subqueue when it is 0. The field `cmb_code` is decoded as follows: bit0=1 means a precharge is needed, bit1=1 means an activate is needed, and bit2=1 means the column access carries auto-precharge.
- R2: An entry issues its subcommands in the order precharge, activate, column access, and skips the steps its code leaves out. Kinds are encoded as 0=precharge, 1=activate, 2=column access, 3=column access with auto-precharge.
- R3: `ready_vec` bit `kind*NUM_DIMM + dimm` is 1 exactly when some live entry's next subcommand is that kind for that DIMM. A new entry appears there after the clock edge that accepts it.
- R4: The selector grants the first set ready bit at or above its pointer, wrapping around. The pointer is 0 after reset and moves to one past each granted bit. At most one subcommand issues per cycle.
- R5: For a granted kind/DIMM pair, only the entry with the oldest acceptance among both subqueues executes.
- R6: An issued subcommand appears on `iss_valid`, `iss_kind`, `iss_dimm`, `iss_write` and `iss_tag` one clock after the edge at which it was granted. It carries the tag and direction stored with its entry. The entry frees after its column access.
- R7: A combination offered to a full subqueue (DEPTH live entries) is dropped and never issues.
- R8: While `issue_enable` is 0, nothing issues and every entry keeps its pending subcommand.
- R9: `rd_count` and `wr_count` change on the edge that accepts or frees an entry in that subqueue. An accept and a free in the same cycle leave the count unchanged.
- R10: After reset, `iss_valid`=0, both counts are 0 and `ready_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmb_valid | input | 1 | Combination offered this cycle |
| cmb_write | input | 1 | 1 = write, 0 = read |
| cmb_dimm | input | $clog2(NUM_DIMM) | Target DIMM |
| cmb_code | input | 3 | bit0 precharge, bit1 activate, bit2 auto-precharge |
| cmb_tag | input | TAG_W | Transaction tag stored with the entry |
| issue_enable | input | 1 | Allows one issue this cycle |
| iss_valid | output | 1 | Subcommand issued |
| iss_kind | output | 2 | Issued subcommand kind |
| iss_dimm | output | $clog2(NUM_DIMM) | Issued DIMM |
| iss_write | output | 1 | Issuing entry came from the write subqueue |
| iss_tag | output | TAG_W | Tag of the issuing entry |
| rd_count | output | $clog2(DEPTH+1) | Read subqueue occupancy |
| wr_count | output | $clog2(DEPTH+1) | Write subqueue occupancy |
| ready_vec | output | 4*NUM_DIMM | Pending kind-by-DIMM vector |

## Verification
The hardest situation to reach is several live entries competing at once: older entries waiting behind younger ones of another kind, and equal kind/DIMM pairs spread over both subqueues. With issue always open, each entry would drain as soon as it arrived.

The bench therefore holds `issue_enable` low while it loads a chosen set of combinations. It then opens issue and predicts each grant from the round-robin pointer. That pointer is known exactly because every scenario starts from reset. One scenario also times an accept to land on the same edge as a retire, to exercise the unchanged-count case.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

    localparam int NUM_KIND = 4;
    localparam int SEQ_W    = 8;

    typedef enum logic [1:0] {
        K_PRE   = 2'd0,
        K_RAS   = 2'd1,
        K_CAS   = 2'd2,
        K_CASAP = 2'd3
    } sub_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_PRE,
        ST_WAIT_RAS,
        ST_WAIT_CAS,
        ST_WAIT_CASAP
    } ent_state_e;

    typedef struct packed {
        logic autopre;
        logic need_ras;
        logic need_pre;
    } combo_t;

    // Wrap-safe age compare: live sequence numbers span far less than half the range.
    function automatic logic seq_older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

endpackage

// File: rtl/sdq_entry.sv
module sdq_entry
    import sdq_pkg::*;
#(
    parameter int DIMM_W = 2,
    parameter int TAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  combo_t            combo_i,
    input  logic [DIMM_W-1:0] dimm_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [SEQ_W-1:0]  seq_i,
    input  logic              exec_i,
    output logic              busy_o,
    output sub_kind_e         kind_o,
    output logic [DIMM_W-1:0] dimm_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [SEQ_W-1:0]  seq_o
);

    ent_state_e        state_q, state_nx;
    combo_t            combo_q;
    logic [DIMM_W-1:0] dimm_q;
    logic [TAG_W-1:0]  tag_q;
    logic [SEQ_W-1:0]  seq_q;
    ent_state_e        final_st;
    ent_state_e        first_st;

    assign final_st = combo_q.autopre ? ST_WAIT_CASAP : ST_WAIT_CAS;

    always_comb begin
        if (combo_i.need_pre)      first_st = ST_WAIT_PRE;
        else if (combo_i.need_ras) first_st = ST_WAIT_RAS;
        else if (combo_i.autopre)  first_st = ST_WAIT_CASAP;
        else                       first_st = ST_WAIT_CAS;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:       if (alloc_i) state_nx = first_st;
            ST_WAIT_PRE:   if (exec_i)  state_nx = combo_q.need_ras ? ST_WAIT_RAS : final_st;
            ST_WAIT_RAS:   if (exec_i)  state_nx = final_st;
            ST_WAIT_CAS,
            ST_WAIT_CASAP: if (exec_i)  state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            combo_q <= '0;
            dimm_q  <= '0;
            tag_q   <= '0;
            seq_q   <= '0;
        end else if (alloc_i && state_q == ST_IDLE) begin
            combo_q <= combo_i;
            dimm_q  <= dimm_i;
            tag_q   <= tag_i;
            seq_q   <= seq_i;
        end
    end

    // outputs
    always_comb begin
        busy_o = 1'b1;
        kind_o = K_PRE;
        unique case (state_q)
            ST_IDLE:       busy_o = 1'b0;
            ST_WAIT_PRE:   kind_o = K_PRE;
            ST_WAIT_RAS:   kind_o = K_RAS;
            ST_WAIT_CAS:   kind_o = K_CAS;
            ST_WAIT_CASAP: kind_o = K_CASAP;
            default:       busy_o = 1'b0;
        endcase
    end

    assign dimm_o = dimm_q;
    assign tag_o  = tag_q;
    assign seq_o  = seq_q;

    AST_ALLOC_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> state_q == ST_IDLE); // R1
    AST_EXEC_LIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i |-> state_q != ST_IDLE); // R5

endmodule

// File: rtl/sdq_subqueue.sv
module sdq_subqueue
    import sdq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int NUM_DIMM = 4,
    parameter int TAG_W    = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_req_i,
    input  combo_t                       combo_i,
    input  logic [$clog2(NUM_DIMM)-1:0]  dimm_i,
    input  logic [TAG_W-1:0]             tag_i,
    input  logic [SEQ_W-1:0]             seq_i,
    input  sub_kind_e                    sel_kind_i,
    input  logic [$clog2(NUM_DIMM)-1:0]  sel_dimm_i,
    input  logic                         exec_grant_i,
    output logic                         accept_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic [NUM_KIND*NUM_DIMM-1:0] ready_o,
    output logic                         hit_o,
    output logic [SEQ_W-1:0]             hit_seq_o,
    output logic [TAG_W-1:0]             hit_tag_o
);

    localparam int DIMM_W = $clog2(NUM_DIMM);
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH+1);

    logic [DEPTH-1:0]  busy_v;
    logic [DEPTH-1:0]  alloc_v;
    logic [DEPTH-1:0]  exec_v;
    sub_kind_e         kind_a [DEPTH];
    logic [DIMM_W-1:0] dimm_a [DEPTH];
    logic [TAG_W-1:0]  tag_a  [DEPTH];
    logic [SEQ_W-1:0]  seq_a  [DEPTH];

    logic              free_found;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  hit_idx;
    logic              free_evt;
    logic [CNT_W-1:0]  count_q;

    // lowest idle slot
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!free_found && !busy_v[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign accept_o = alloc_req_i && free_found;

    // oldest live entry pending the selected kind/DIMM
    always_comb begin
        hit_o     = 1'b0;
        hit_idx   = '0;
        hit_seq_o = '0;
        hit_tag_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (busy_v[i] && kind_a[i] == sel_kind_i && dimm_a[i] == sel_dimm_i &&
                (!hit_o || seq_older(seq_a[i], hit_seq_o))) begin
                hit_o     = 1'b1;
                hit_idx   = IDX_W'(i);
                hit_seq_o = seq_a[i];
                hit_tag_o = tag_a[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            assign alloc_v[g] = accept_o && (free_idx == IDX_W'(g));
            assign exec_v[g]  = exec_grant_i && hit_o && (hit_idx == IDX_W'(g));
            sdq_entry #(.DIMM_W(DIMM_W), .TAG_W(TAG_W)) u_ent (
                .clk     (clk),
                .rst_n   (rst_n),
                .alloc_i (alloc_v[g]),
                .combo_i (combo_i),
                .dimm_i  (dimm_i),
                .tag_i   (tag_i),
                .seq_i   (seq_i),
                .exec_i  (exec_v[g]),
                .busy_o  (busy_v[g]),
                .kind_o  (kind_a[g]),
                .dimm_o  (dimm_a[g]),
                .tag_o   (tag_a[g]),
                .seq_o   (seq_a[g])
            );
        end

        for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
            for (genvar d = 0; d < NUM_DIMM; d++) begin : g_dimm
                logic [DEPTH-1:0] pend;
                for (genvar e = 0; e < DEPTH; e++) begin : g_pend
                    assign pend[e] = busy_v[e] && (kind_a[e] == sub_kind_e'(k)) &&
                                     (dimm_a[e] == DIMM_W'(d));
                end
                assign ready_o[k*NUM_DIMM + d] = |pend;
            end
        end
    endgenerate

    assign free_evt = exec_grant_i && hit_o && (sel_kind_i == K_CAS || sel_kind_i == K_CASAP);

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_q + CNT_W'(accept_o) - CNT_W'(free_evt);
    end

    assign count_o = count_q;

    AST_EXEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exec_v)); // R5
    AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) == $countones(busy_v)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH)); // R7

endmodule

// File: rtl/sdq_rr_arbiter.sv
module sdq_rr_arbiter #(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req_i,
    input  logic                 adv_i,
    output logic                 grant_valid_o,
    output logic [$clog2(N)-1:0] grant_idx_o
);

    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] ptr_q;

    always_comb begin
        grant_valid_o = 1'b0;
        grant_idx_o   = '0;
        for (int off = 0; off < N; off++) begin
            int j;
            j = (int'(ptr_q) + off) % N;
            if (!grant_valid_o && req_i[j]) begin
                grant_valid_o = 1'b1;
                grant_idx_o   = IDX_W'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv_i && grant_valid_o) begin
            ptr_q <= (grant_idx_o == IDX_W'(N-1)) ? '0 : grant_idx_o + IDX_W'(1);
        end
    end

endmodule

// File: rtl/sdq_dispatch_issue.sv
module sdq_dispatch_issue
    import sdq_pkg::*;
#(
    parameter int NUM_DIMM = 4,
    parameter int DEPTH    = 8,
    parameter int TAG_W    = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmb_valid,
    input  logic                         cmb_write,
    input  logic [$clog2(NUM_DIMM)-1:0]  cmb_dimm,
    input  logic [2:0]                   cmb_code,
    input  logic [TAG_W-1:0]             cmb_tag,
    input  logic                         issue_enable,
    output logic                         iss_valid,
    output logic [1:0]                   iss_kind,
    output logic [$clog2(NUM_DIMM)-1:0]  iss_dimm,
    output logic                         iss_write,
    output logic [TAG_W-1:0]             iss_tag,
    output logic [$clog2(DEPTH+1)-1:0]   rd_count,
    output logic [$clog2(DEPTH+1)-1:0]   wr_count,
    output logic [NUM_KIND*NUM_DIMM-1:0] ready_vec
);

    localparam int DIMM_W    = $clog2(NUM_DIMM);
    localparam int RDY_W     = NUM_KIND * NUM_DIMM;
    localparam int RDY_IDX_W = $clog2(RDY_W);

    logic [SEQ_W-1:0]     seq_q;
    logic                 rd_acc, wr_acc;
    logic [RDY_W-1:0]     rd_ready, wr_ready;
    logic                 rd_hit, wr_hit;
    logic [SEQ_W-1:0]     rd_seq, wr_seq;
    logic [TAG_W-1:0]     rd_tag, wr_tag;
    logic                 grant_valid;
    logic [RDY_IDX_W-1:0] grant_idx;
    sub_kind_e            sel_kind;
    logic [DIMM_W-1:0]    sel_dimm;
    logic                 sel_go;
    logic                 win_write;
    combo_t               combo_in;

    assign combo_in = combo_t'(cmb_code);
    assign sel_kind = sub_kind_e'(grant_idx[RDY_IDX_W-1 -: 2]);
    assign sel_dimm = grant_idx[DIMM_W-1:0];
    assign sel_go   = grant_valid && issue_enable;
    assign win_write = wr_hit && (!rd_hit || seq_older(wr_seq, rd_seq));

    sdq_subqueue #(.DEPTH(DEPTH), .NUM_DIMM(NUM_DIMM), .TAG_W(TAG_W)) u_rdq (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_req_i  (cmb_valid && !cmb_write),
        .combo_i      (combo_in),
        .dimm_i       (cmb_dimm),
        .tag_i        (cmb_tag),
        .seq_i        (seq_q),
        .sel_kind_i   (sel_kind),
        .sel_dimm_i   (sel_dimm),
        .exec_grant_i (sel_go && !win_write),
        .accept_o     (rd_acc),
        .count_o      (rd_count),
        .ready_o      (rd_ready),
        .hit_o        (rd_hit),
        .hit_seq_o    (rd_seq),
        .hit_tag_o    (rd_tag)
    );

    sdq_subqueue #(.DEPTH(DEPTH), .NUM_DIMM(NUM_DIMM), .TAG_W(TAG_W)) u_wrq (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_req_i  (cmb_valid && cmb_write),
        .combo_i      (combo_in),
        .dimm_i       (cmb_dimm),
        .tag_i        (cmb_tag),
        .seq_i        (seq_q),
        .sel_kind_i   (sel_kind),
        .sel_dimm_i   (sel_dimm),
        .exec_grant_i (sel_go && win_write),
        .accept_o     (wr_acc),
        .count_o      (wr_count),
        .ready_o      (wr_ready),
        .hit_o        (wr_hit),
        .hit_seq_o    (wr_seq),
        .hit_tag_o    (wr_tag)
    );

    assign ready_vec = rd_ready | wr_ready;

    sdq_rr_arbiter #(.N(RDY_W)) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (ready_vec),
        .adv_i         (issue_enable),
        .grant_valid_o (grant_valid),
        .grant_idx_o   (grant_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                seq_q <= '0;
        else if (rd_acc || wr_acc) seq_q <= seq_q + SEQ_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            iss_kind  <= '0;
            iss_dimm  <= '0;
            iss_write <= 1'b0;
            iss_tag   <= '0;
        end else begin
            iss_valid <= sel_go;
            if (sel_go) begin
                iss_kind  <= sel_kind;
                iss_dimm  <= sel_dimm;
                iss_write <= win_write;
                iss_tag   <= win_write ? wr_tag : rd_tag;
            end
        end
    end

    AST_HOLD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_enable |=> !iss_valid); // R8
    AST_GRANT_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        sel_go |-> (rd_hit || wr_hit)); // R5
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_acc && wr_acc)); // R1

endmodule

// File: tb/sdq_dispatch_issue_tb.sv
module sdq_dispatch_issue_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmb_valid, cmb_write, issue_enable;
    logic [1:0] cmb_dimm;
    logic [2:0] cmb_code;
    logic [5:0] cmb_tag;
    logic       iss_valid, iss_write;
    logic [1:0] iss_kind, iss_dimm;
    logic [5:0] iss_tag;
    logic [3:0] rd_count, wr_count;
    logic [15:0] ready_vec;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sdq_dispatch_issue dut_i (
        .clk(clk), .rst_n(rst_n), .cmb_valid(cmb_valid), .cmb_write(cmb_write),
        .cmb_dimm(cmb_dimm), .cmb_code(cmb_code), .cmb_tag(cmb_tag),
        .issue_enable(issue_enable), .iss_valid(iss_valid), .iss_kind(iss_kind),
        .iss_dimm(iss_dimm), .iss_write(iss_write), .iss_tag(iss_tag),
        .rd_count(rd_count), .wr_count(wr_count), .ready_vec(ready_vec)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmb_valid = 1'b0; cmb_write = 1'b0; cmb_dimm = '0;
        cmb_code = '0; cmb_tag = '0; issue_enable = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic push(input logic wr, input int dimm, input int code, input int tag);
        cmb_valid = 1'b1; cmb_write = wr; cmb_dimm = 2'(dimm);
        cmb_code = 3'(code); cmb_tag = 6'(tag);
        tick();
        cmb_valid = 1'b0;
    endtask

    task automatic expect_iss(input string req, input int kind, input int dimm, input int tag, input int wr);
        chk(req, "iss_valid", int'(iss_valid), 1);
        chk(req, "iss_kind",  int'(iss_kind),  kind);
        chk(req, "iss_dimm",  int'(iss_dimm),  dimm);
        chk(req, "iss_tag",   int'(iss_tag),   tag);
        chk(req, "iss_write", int'(iss_write), wr);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10", "iss_valid", int'(iss_valid), 0);
        chk("R10", "rd_count", int'(rd_count), 0);
        chk("R10", "wr_count", int'(wr_count), 0);
        chk("R10", "ready_vec", int'(ready_vec), 0);
    endtask

    task automatic t_sequence();
        do_reset();
        push(1'b0, 2, 3'b111, 5);
        chk("R9", "rd_count after accept", int'(rd_count), 1);
        chk("R3", "ready_vec PRE dimm2", int'(ready_vec), 16'h0004);
        issue_enable = 1'b1;
        tick(); expect_iss("R2", 0, 2, 5, 0);
        tick(); expect_iss("R2", 1, 2, 5, 0);
        tick(); expect_iss("R6", 3, 2, 5, 0);
        chk("R6", "rd_count after retire", int'(rd_count), 0);
        tick();
        chk("R6", "iss_valid idle", int'(iss_valid), 0);
    endtask

    task automatic t_direction();
        do_reset();
        push(1'b0, 0, 0, 1);
        push(1'b1, 1, 0, 2);
        push(1'b1, 2, 0, 3);
        chk("R1", "rd_count", int'(rd_count), 1);
        chk("R1", "wr_count", int'(wr_count), 2);
        chk("R3", "ready_vec CAS", int'(ready_vec), 16'h0700);
        issue_enable = 1'b1;
        tick(); expect_iss("R1", 2, 0, 1, 0);
        tick(); expect_iss("R1", 2, 1, 2, 1);
        tick(); expect_iss("R1", 2, 2, 3, 1);
        chk("R9", "wr_count drained", int'(wr_count), 0);
    endtask

    task automatic t_oldest();
        do_reset();
        push(1'b1, 1, 0, 10);
        push(1'b0, 1, 0, 11);
        push(1'b1, 1, 0, 12);
        issue_enable = 1'b1;
        tick(); expect_iss("R5", 2, 1, 10, 1);
        tick(); expect_iss("R5", 2, 1, 11, 0);
        tick(); expect_iss("R5", 2, 1, 12, 1);
    endtask

    task automatic t_round_robin();
        do_reset();
        push(1'b0, 3, 3'b000, 20);
        push(1'b0, 0, 3'b001, 21);
        push(1'b1, 1, 3'b110, 22);
        chk("R3", "ready_vec mixed", int'(ready_vec), 16'h0821);
        issue_enable = 1'b1;
        tick(); expect_iss("R4", 0, 0, 21, 0);
        tick(); expect_iss("R4", 1, 1, 22, 1);
        tick(); expect_iss("R4", 2, 0, 21, 0);
        tick(); expect_iss("R4", 2, 3, 20, 0);
        tick(); expect_iss("R4", 3, 1, 22, 1);
        tick();
        chk("R4", "iss_valid drained", int'(iss_valid), 0);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 9; i++) push(1'b0, 0, 0, i);
        chk("R7", "rd_count capped", int'(rd_count), 8);
        issue_enable = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(); expect_iss("R7", 2, 0, i, 0);
        end
        tick();
        chk("R7", "dropped never issues", int'(iss_valid), 0);
        chk("R7", "rd_count empty", int'(rd_count), 0);
    endtask

    task automatic t_hold();
        do_reset();
        push(1'b0, 0, 3'b001, 7);
        tick(); tick();
        chk("R8", "no issue while held", int'(iss_valid), 0);
        chk("R8", "ready held PRE", int'(ready_vec), 16'h0001);
        chk("R8", "rd_count held", int'(rd_count), 1);
        issue_enable = 1'b1;
        tick(); expect_iss("R8", 0, 0, 7, 0);
        issue_enable = 1'b0;
        tick();
        chk("R8", "no issue after hold", int'(iss_valid), 0);
        chk("R8", "ready held CAS", int'(ready_vec), 16'h0100);
        issue_enable = 1'b1;
        tick(); expect_iss("R8", 2, 0, 7, 0);
    endtask

    task automatic t_overlap();
        do_reset();
        push(1'b0, 0, 0, 1);
        issue_enable = 1'b1;
        push(1'b0, 3, 0, 2);
        expect_iss("R9", 2, 0, 1, 0);
        chk("R9", "count with accept and free", int'(rd_count), 1);
        tick(); expect_iss("R9", 2, 3, 2, 0);
        chk("R9", "count after last free", int'(rd_count), 0);
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_direction();
        t_oldest();
        t_round_robin();
        t_full();
        t_hold();
        t_overlap();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule